// File: doc/BRIEF.md
# Asynchronous Memory Read Strobe Generator

This block runs read cycles toward a slow 8-bit asynchronous device on an external memory bus, such as a FIFO or a register bank inside a programmable logic part. A requester (a DMA engine or a processor port) hands over one address at a time. The block then drives an active-low chip select, an active-low read strobe and the address through three timed phases: setup, strobe and hold. The read data is latched on the clock edge that closes the strobe.

The length of each phase is given in bus clock cycles. Setup and hold may each be 0 to 15 cycles. The strobe lasts at least one cycle. The timing is sampled when a request is accepted and stays fixed for that access. For example, a 3-1-2 setting on a 100 MHz bus takes 60 ns per read, and a 1-3-1 setting takes 50 ns. A device that needs more time can hold its ready line low to stretch the strobe. That line is asynchronous, so it passes through a two-stage synchronizer before the block uses it.

A request presented during the final cycle of an access is taken at once. A stream of reads therefore runs with no idle cycle between accesses.

Top module: `async_rd_seq`

## Requirements
- R1: While reset is low, and in the cycle after a reset applied in the middle of an access, `bus_ce_n` and `bus_re_n` are 1, `rd_valid` is 0 and `req_ready` is 1.
- R2: After a request is accepted, the access opens with `cfg_setup` cycles (0 to 15) in which `bus_ce_n` is 0 and `bus_re_n` is 1.
- R3: With ready held high, `bus_re_n` is 0 for exactly `cfg_strobe` consecutive cycles that directly follow the setup phase, and `bus_re_n` is never 0 while `bus_ce_n` is 1.
- R4: After the strobe phase, `bus_ce_n` stays 0 and `bus_re_n` stays 1 for `cfg_hold` cycles (0 to 15). Then `bus_ce_n` returns to 1 if no further request is taken.
- R5: `bus_addr` equals the accepted `req_addr` in every cycle of the access and does not change within it.
- R6: `rd_data` holds the `bus_data` value present at the last strobe edge. `rd_valid` is 1 for exactly one cycle, the cycle right after the last strobe cycle.
- R7: `bus_rdy` passes through a two-flop synchronizer. The strobe ends only in a cycle where its programmed count has elapsed and the synchronized ready is 1. A rise of `bus_rdy` therefore ends a stretched strobe two cycles later.
- R8: `req_ready` is 1 while idle and in the final cycle of an access (the last hold cycle, or the last strobe cycle when hold is 0), and 0 in all other cycles. A request is taken when `req_valid` and `req_ready` are both 1.
- R9: A request taken in the final cycle starts its own setup phase (or strobe phase, if setup is 0) in the next cycle. `bus_ce_n` stays 0 across the whole run.
- R10: Changes to `cfg_setup`, `cfg_strobe`, `cfg_hold` and `req_addr` after acceptance have no effect on the access in progress.
- R11: A `cfg_strobe` value of 0 gives a one-cycle strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_addr | input | ADDR_W | Address of the requested read |
| cfg_setup | input | CFG_W | Setup phase length in cycles |
| cfg_strobe | input | CFG_W | Strobe phase length in cycles (0 acts as 1) |
| cfg_hold | input | CFG_W | Hold phase length in cycles |
| bus_rdy | input | 1 | Asynchronous device ready; low stretches the strobe |
| bus_ce_n | output | 1 | Device chip select, active low |
| bus_re_n | output | 1 | Device read strobe, active low |
| bus_addr | output | ADDR_W | Device address |
| bus_data | input | DATA_W | Device read data |
| rd_data | output | DATA_W | Captured read data |
| rd_valid | output | 1 | One-cycle pulse marking new `rd_data` |

## Verification
The phase counts are tried over a table of timing triples. These include the 0-1-0 minimum, the 3-1-2 and 1-3-1 settings, setup and hold at 15, strobe at 15, and a strobe of 0. This separates a wrong phase order, an off-by-one in any single counter and a missing clamp on the strobe length. The device model changes its data as soon as the strobe rises, so a capture taken one edge late returns the wrong byte. Ready is released once late and once early, which shows both that the strobe stretches and that an early ready adds nothing to the programmed count. Back-to-back pairs, timing inputs scrambled during an access, and a reset in the middle of a strobe expose lost idle cycles, unlatched settings and residual state.

// File: rtl/async_rd_pkg.sv
// Package: shared types of the asynchronous read sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package async_rd_pkg;
    // Access phase of the read sequencer.
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_STROBE = 2'd2,
        PH_HOLD   = 2'd3
    } rd_phase_e;
endpackage

// File: rtl/async_rd_sync.sv
// Module: multi-stage synchronizer for a single asynchronous level.
// Assumes: STAGES >= 2; the input is a slowly changing level, not a pulse.
// The output resets to 0 (not ready), so a stretched strobe is never cut short.
module async_rd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_q;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], async_in};
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/async_rd_phase_ctr.sv
// Module: down counter that times one access phase.
// Assumes: load carries (phase length - 1); zero marks the phase's last cycle.
// Once the counter is at zero it stays there, which lets the strobe stretch.
module async_rd_phase_ctr #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    // Load on a phase change, otherwise count down to zero and stop.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt_q <= '0;
        else if (load)       cnt_q <= load_val;
        else if (cnt_q != 0) cnt_q <= cnt_q - W'(1);
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/async_rd_capture.sv
// Module: read data capture register with a one-cycle valid pulse.
// Assumes: take is high in the last strobe cycle only, so the bus data is latched
// on the edge that closes the strobe.
module async_rd_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [DATA_W-1:0] bus_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    // Latch data at the closing strobe edge.
    always_ff @(posedge clk) begin
        if (!rst_n)    rd_data <= '0;
        else if (take) rd_data <= bus_data;
    end

    // Raise valid for the single cycle after the capture.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_valid <= 1'b0;
        else        rd_valid <= take;
    end
endmodule

// File: rtl/async_rd_seq.sv
// Module: asynchronous memory read strobe generator (top).
// Runs one read access per accepted request as setup, strobe and hold phases
// counted in clock cycles. The phase lengths are latched at acceptance.
// Assumes: the device drives bus_data valid before the end of the strobe;
// bus_rdy is asynchronous and may be tied high.
module async_rd_seq #(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 8,
    parameter int CFG_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CFG_W-1:0]  cfg_setup,
    input  logic [CFG_W-1:0]  cfg_strobe,
    input  logic [CFG_W-1:0]  cfg_hold,
    input  logic              bus_rdy,
    output logic              bus_ce_n,
    output logic              bus_re_n,
    output logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    import async_rd_pkg::*;

    // Strobe length minus one, with 0 treated as a one-cycle strobe.
    function automatic logic [CFG_W-1:0] strobe_m1(input logic [CFG_W-1:0] v);
        return (v == '0) ? '0 : v - CFG_W'(1);
    endfunction

    rd_phase_e         phase_q, phase_d;
    logic [ADDR_W-1:0] addr_q;
    logic [CFG_W-1:0]  strobe_q, hold_q;
    logic              rdy_s;
    logic              cnt_zero, cnt_load;
    logic [CFG_W-1:0]  cnt_val;
    logic              accept, strobe_done, last_cycle;
    rd_phase_e         first_phase;
    logic [CFG_W-1:0]  first_val;

    async_rd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (bus_rdy),
        .sync_out (rdy_s)
    );

    async_rd_phase_ctr #(.W(CFG_W)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .zero     (cnt_zero)
    );

    async_rd_capture #(.DATA_W(DATA_W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (strobe_done),
        .bus_data (bus_data),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    // Decide when the strobe closes and when the access ends.
    always_comb begin
        strobe_done = (phase_q == PH_STROBE) && cnt_zero && rdy_s;
        last_cycle  = ((phase_q == PH_HOLD) && cnt_zero) ||
                      (strobe_done && (hold_q == '0));
        req_ready   = (phase_q == PH_IDLE) || last_cycle;
        accept      = req_valid && req_ready;
    end

    // Work out the first phase of a newly accepted access from the live timing inputs.
    always_comb begin
        if (cfg_setup != '0) begin
            first_phase = PH_SETUP;
            first_val   = cfg_setup - CFG_W'(1);
        end else begin
            first_phase = PH_STROBE;
            first_val   = strobe_m1(cfg_strobe);
        end
    end

    // Next phase and counter reload.
    always_comb begin
        phase_d  = phase_q;
        cnt_load = 1'b0;
        cnt_val  = '0;
        unique case (phase_q)
            PH_IDLE: begin
                if (accept) begin
                    phase_d  = first_phase;
                    cnt_load = 1'b1;
                    cnt_val  = first_val;
                end
            end
            PH_SETUP: begin
                if (cnt_zero) begin
                    phase_d  = PH_STROBE;
                    cnt_load = 1'b1;
                    cnt_val  = strobe_m1(strobe_q);
                end
            end
            PH_STROBE: begin
                if (strobe_done) begin
                    if (hold_q != '0) begin
                        phase_d  = PH_HOLD;
                        cnt_load = 1'b1;
                        cnt_val  = hold_q - CFG_W'(1);
                    end else if (accept) begin
                        phase_d  = first_phase;
                        cnt_load = 1'b1;
                        cnt_val  = first_val;
                    end else begin
                        phase_d  = PH_IDLE;
                    end
                end
            end
            PH_HOLD: begin
                if (cnt_zero) begin
                    if (accept) begin
                        phase_d  = first_phase;
                        cnt_load = 1'b1;
                        cnt_val  = first_val;
                    end else begin
                        phase_d  = PH_IDLE;
                    end
                end
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    // Latch the address and the strobe and hold lengths at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q   <= '0;
            strobe_q <= '0;
            hold_q   <= '0;
        end else if (accept) begin
            addr_q   <= req_addr;
            strobe_q <= cfg_strobe;
            hold_q   <= cfg_hold;
        end
    end

    assign bus_ce_n = (phase_q == PH_IDLE);
    assign bus_re_n = (phase_q != PH_STROBE);
    assign bus_addr = addr_q;
endmodule

// File: rtl/async_rd_seq_chk.sv
// Module: protocol checker for async_rd_seq, attached by bind below.
// Assumes: observes top-level ports only.
module async_rd_seq_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              bus_rdy,
    input logic              bus_ce_n,
    input logic              bus_re_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              rd_valid
);
    // The read strobe is only active inside a chip-select window.
    assert_re_in_ce_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re_n |-> !bus_ce_n);

    // Valid data follows a strobe cycle directly.
    assert_valid_after_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(!bus_re_n));

    // The address holds inside an access.
    assert_addr_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_ce_n && $past(!bus_ce_n) && !$past(req_valid && req_ready)) |-> $stable(bus_addr));

    // An idle bus always takes a request.
    assert_idle_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ce_n |-> req_ready);

    // A ready seen low through the synchronizer keeps the strobe active.
    assert_stretch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_re_n && !$past(bus_rdy, 2)) |=> !bus_re_n);
endmodule

bind async_rd_seq async_rd_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .bus_rdy   (bus_rdy),
    .bus_ce_n  (bus_ce_n),
    .bus_re_n  (bus_re_n),
    .bus_addr  (bus_addr),
    .rd_valid  (rd_valid)
);

// File: tb/async_rd_seq_bench.sv
// Bench: table-driven timing sweep, then directed ready, back-to-back and reset tests.
module async_rd_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [15:0] req_addr = '0;
    logic [3:0]  cfg_setup = '0, cfg_strobe = '0, cfg_hold = '0;
    logic        bus_rdy = 1'b1;
    logic        bus_ce_n, bus_re_n;
    logic [15:0] bus_addr;
    logic [7:0]  bus_data, rd_data;
    logic        rd_valid;
    int          n_checks = 0;
    int          n_err = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    // Device model: data tied to the address during the strobe, zero otherwise.
    assign bus_data = bus_re_n ? 8'h00 : (bus_addr[7:0] ^ 8'h5A);

    async_rd_seq u_async_rd_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .cfg_setup(cfg_setup), .cfg_strobe(cfg_strobe),
        .cfg_hold(cfg_hold), .bus_rdy(bus_rdy), .bus_ce_n(bus_ce_n),
        .bus_re_n(bus_re_n), .bus_addr(bus_addr), .bus_data(bus_data),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    // Each entry: {setup, strobe, hold, address}.
    localparam logic [27:0] VEC [8] = '{
        {4'd3,  4'd1,  4'd2,  16'h0011},
        {4'd1,  4'd3,  4'd1,  16'h0122},
        {4'd0,  4'd1,  4'd0,  16'h0233},
        {4'd0,  4'd0,  4'd0,  16'h0344},
        {4'd15, 4'd2,  4'd15, 16'h04F5},
        {4'd2,  4'd15, 4'd0,  16'h0566},
        {4'd0,  4'd4,  4'd3,  16'h0677},
        {4'd5,  4'd1,  4'd0,  16'h0788}
    };

    task automatic check(input bit ok, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    // One access; rel >= 0 holds ready low until rel strobe cycles have been seen.
    task automatic run_one(input int s, input int t, input int h,
                           input logic [15:0] a, input int rel);
        int tt, exp_str, n_set, n_str, n_hold, n_val, n_rdy;
        bit addr_ok, val_ok, prev_str;
        logic [7:0] vdat;
        tt = (t == 0) ? 1 : t;
        exp_str = tt;
        if (rel >= 0 && rel + 2 > tt) exp_str = rel + 2;
        n_set = 0; n_str = 0; n_hold = 0; n_val = 0; n_rdy = 0;
        addr_ok = 1'b1; val_ok = 1'b1; prev_str = 1'b0; vdat = '0;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        cfg_setup = 4'(s); cfg_strobe = 4'(t); cfg_hold = 4'(h);
        if (rel >= 0) bus_rdy = 1'b0;
        check(req_ready === 1'b1, "R8 ready while idle", int'(req_ready), 1);
        @(negedge clk);
        // R10: scramble request and timing inputs during the access.
        req_valid = 1'b0; req_addr = ~a;
        cfg_setup = ~4'(s); cfg_strobe = ~4'(t); cfg_hold = ~4'(h);
        for (int c = 0; c < 100; c++) begin
            if (rd_valid) begin
                n_val++; vdat = rd_data;
                if (!(prev_str && bus_re_n)) val_ok = 1'b0;
            end
            if (bus_ce_n) break;
            if (bus_addr !== a) addr_ok = 1'b0;
            if (req_ready) n_rdy++;
            if (!bus_re_n) begin
                n_str++;
                if (rel >= 0 && n_str == rel) bus_rdy = 1'b1;
            end else if (n_str == 0) n_set++;
            else n_hold++;
            prev_str = !bus_re_n;
            @(negedge clk);
        end
        bus_rdy = 1'b1;
        check(n_set == s, "R2 setup cycles", n_set, s);
        check(n_str == exp_str, "R3/R7/R10/R11 strobe cycles", n_str, exp_str);
        check(n_hold == h, "R4 hold cycles", n_hold, h);
        check(addr_ok, "R5 address held", int'(addr_ok), 1);
        check(n_val == 1 && val_ok, "R6 single valid after strobe", n_val, 1);
        check(vdat == (a[7:0] ^ 8'h5A), "R6 captured data", int'(vdat), int'(a[7:0] ^ 8'h5A));
        check(n_rdy == 1, "R8 ready only in final cycle", n_rdy, 1);
    endtask

    // Two requests back to back with the same timing.
    task automatic run_pair(input int s, input int t, input int h,
                            input logic [15:0] a1, input logic [15:0] a2);
        int tt, n_ce, n_str, n_val;
        bit drop;
        logic [7:0] d [2];
        tt = (t == 0) ? 1 : t;
        n_ce = 0; n_str = 0; n_val = 0; drop = 1'b0; d[0] = '0; d[1] = '0;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a1;
        cfg_setup = 4'(s); cfg_strobe = 4'(t); cfg_hold = 4'(h);
        @(negedge clk);
        req_addr = a2;
        for (int c = 0; c < 100; c++) begin
            if (rd_valid) begin
                if (n_val < 2) d[n_val] = rd_data;
                n_val++;
            end
            if (bus_ce_n) break;
            n_ce++;
            if (!bus_re_n) n_str++;
            if (drop) req_valid = 1'b0;
            else if (req_ready) drop = 1'b1;
            @(negedge clk);
        end
        req_valid = 1'b0;
        check(n_ce == 2 * (s + tt + h), "R9 chip select unbroken", n_ce, 2 * (s + tt + h));
        check(n_str == 2 * tt, "R9 strobe cycles in pair", n_str, 2 * tt);
        check(n_val == 2, "R9 two valid pulses", n_val, 2);
        check(d[0] == (a1[7:0] ^ 8'h5A), "R9 first data", int'(d[0]), int'(a1[7:0] ^ 8'h5A));
        check(d[1] == (a2[7:0] ^ 8'h5A), "R9 second data", int'(d[1]), int'(a2[7:0] ^ 8'h5A));
    endtask

    task automatic check_idle(input string tag);
        check(bus_ce_n === 1'b1, {tag, " ce_n"}, int'(bus_ce_n), 1);
        check(bus_re_n === 1'b1, {tag, " re_n"}, int'(bus_re_n), 1);
        check(rd_valid === 1'b0, {tag, " rd_valid"}, int'(rd_valid), 0);
        check(req_ready === 1'b1, {tag, " req_ready"}, int'(req_ready), 1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_err++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check_idle("R1 in reset");
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // Table sweep of timing triples with ready held high.
        foreach (VEC[i]) begin
            run_one(int'(VEC[i][27:24]), int'(VEC[i][23:20]), int'(VEC[i][19:16]),
                    VEC[i][15:0], -1);
            repeat (2) @(negedge clk);
        end

        // R7: late ready stretches; early ready adds nothing.
        run_one(1, 2, 1, 16'h0901, 5);
        repeat (3) @(negedge clk);
        run_one(2, 1, 2, 16'h0902, 3);
        repeat (3) @(negedge clk);
        run_one(0, 6, 0, 16'h0903, 1);
        repeat (3) @(negedge clk);

        // R9: back-to-back pairs.
        run_pair(0, 1, 0, 16'h0A10, 16'h0A21);
        repeat (2) @(negedge clk);
        run_pair(2, 3, 1, 16'h0B32, 16'h0B43);
        repeat (2) @(negedge clk);

        // R1: reset in the middle of a strobe.
        @(negedge clk);
        req_valid = 1'b1; req_addr = 16'h0C55;
        cfg_setup = 4'd3; cfg_strobe = 4'd5; cfg_hold = 4'd2;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (4) @(negedge clk);
        check(bus_re_n === 1'b0, "R3 in strobe before reset", int'(bus_re_n), 0);
        rst_n = 1'b0;
        @(negedge clk);
        check_idle("R1 reset mid-access");
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        run_one(1, 3, 1, 16'h0D66, -1);

        finish_run();
    end
endmodule